// File: doc/BRIEF.md
# Strobed Byte Port with Service Request

This block is a general-purpose byte-wide port for a processor bus. It combines a level-sensitive data latch, a two-term device-select decoder, a direction input and a service-request flag. The flag drives an active-low interrupt line. In input mode a peripheral strobes data into the latch, and the falling strobe edge raises a service request. In output mode the processor writes the latch by selecting the device, and the port drives its outputs all the time.

Every asynchronous input first passes through a two-flop synchronizer to the system clock. Latch transparency, strobe edge detection and both clear paths are evaluated in that clock domain. The tri-state output drivers are modelled as a data bus plus a separate enable. An input change that is held across a rising edge reaches the outputs on the third rising clock edge.

Top module: `strobed_io_port`

## Requirements
- R1: The device counts as selected only when `sel_lo_n` is 0 and `sel_hi` is 1. Every other combination of the two leaves it unselected.
- R2: With `out_mode` = 1, `data_oe` is 1 regardless of selection. The latch gate is the select term, so `strobe` has no effect on `data_out`.
- R3: With `out_mode` = 0, `data_oe` is 1 only while the device is selected. When the device is unselected, `data_oe` is 0 whatever the level of `strobe`, and the latch gate is `strobe`.
- R4: While the latch gate is high, `data_out` follows `data_in`. Once the gate is low, `data_out` holds the last value and ignores changes on `data_in`.
- R5: `clear_n` = 0 forces the latch to all zeros when the gate is low. A high gate overrides the clear, and `data_out` keeps following `data_in`.
- R6: `clear_n` = 0 clears the service-request flag.
- R7: A falling edge of `strobe` sets the service-request flag. If a clear by `clear_n` or by selection is seen in the same cycle, the clear wins and the flag stays 0.
- R8: Selecting the device clears the service-request flag.
- R9: `irq_n` is 0 while the flag is set or the device is selected, and 1 otherwise.
- R10: An input change that is stable across a rising clock edge shows at the outputs after the third rising edge: two synchronizer stages plus one state register.
- R11: During reset and right after it, `data_out` is 0, `data_oe` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | DATA_W | Asynchronous byte input to the latch |
| sel_lo_n | input | 1 | Active-low select term |
| sel_hi | input | 1 | Active-high select term |
| out_mode | input | 1 | 1 = output mode, 0 = input mode |
| strobe | input | 1 | Input-mode latch gate; its falling edge requests service |
| clear_n | input | 1 | Active-low clear of latch and request flag |
| data_out | output | DATA_W | Latch contents |
| data_oe | output | 1 | Driver enable standing in for tri-state control |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong latch value shows on `data_out` in the same cycle when the enable is up; otherwise it waits until the next select. A stale or wrongly set request flag shows on `irq_n` one register after the offending strobe edge or clear, but only while the device is unselected, because selection masks the flag. The bench therefore deselects after every select to expose whether the flag was cleared. A per-clock reference model catches any of these errors three edges after the input that caused it.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef struct packed {
        logic sel_lo_n;
        logic sel_hi;
        logic mode;
        logic strobe;
        logic clear_n;
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);
    localparam ctl_t CTL_IDLE = '{sel_lo_n: 1'b1, sel_hi: 1'b0, mode: 1'b0,
                                  strobe: 1'b0, clear_n: 1'b1};
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_async,
    output logic [W-1:0] out_sync
);
    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = in_async;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= chain_d[i];
        end
    end

    assign out_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sio_latch.sv
module sio_latch #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate,
    input  logic              clear_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic [DATA_W-1:0] val;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (gate)          st_d.val = din;
        else if (!clear_n) st_d.val = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.val;

    // R4
    follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate) |-> dout == $past(din));
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!gate) && $past(clear_n)) |-> $stable(dout));
    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!gate) && $past(!clear_n)) |-> dout == '0);
endmodule

// File: rtl/sio_req.sv
module sio_req (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic selected,
    input  logic clear_n,
    output logic flag
);
    typedef struct packed {
        logic flag;
        logic strobe_prev;
    } req_t;

    req_t st_d, st_q;
    logic fall_edge;
    logic wipe;

    always_comb begin
        fall_edge = st_q.strobe_prev && !strobe;
        wipe      = selected || !clear_n;
        st_d             = st_q;
        st_d.strobe_prev = strobe;
        if (wipe)           st_d.flag = 1'b0;
        else if (fall_edge) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R7
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fall_edge && !wipe) |-> flag);
    // R8
    sel_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(selected) |-> !flag);
    // R6
    clr_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clear_n) |-> !flag);
endmodule

// File: rtl/strobed_io_port.sv
module strobed_io_port #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              out_mode,
    input  logic              strobe,
    input  logic              clear_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              irq_n
);
    import sio_pkg::*;

    typedef struct packed {
        logic sel;
        logic oe;
    } top_t;

    ctl_t              ctl_raw, ctl_s;
    logic [DATA_W-1:0] data_s;
    logic              sel_now;
    logic              gate;
    logic              flag;
    top_t              st_d, st_q;

    assign ctl_raw = '{sel_lo_n: sel_lo_n, sel_hi: sel_hi, mode: out_mode,
                       strobe: strobe, clear_n: clear_n};

    sio_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .in_async(ctl_raw), .out_sync(ctl_s));

    sio_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst_n(rst_n), .in_async(data_in), .out_sync(data_s));

    always_comb begin
        sel_now = !ctl_s.sel_lo_n && ctl_s.sel_hi;
        gate    = ctl_s.mode ? sel_now : ctl_s.strobe;
        st_d.sel = sel_now;
        st_d.oe  = ctl_s.mode || sel_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sio_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .gate(gate), .clear_n(ctl_s.clear_n),
        .din(data_s), .dout(data_out));

    sio_req u_req (
        .clk(clk), .rst_n(rst_n), .strobe(ctl_s.strobe), .selected(sel_now),
        .clear_n(ctl_s.clear_n), .flag(flag));

    assign data_oe = st_q.oe;
    assign irq_n   = !(flag || st_q.sel);

    // R2
    out_mode_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_s.mode) |-> data_oe);
    // R3
    in_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctl_s.mode && (ctl_s.sel_lo_n || !ctl_s.sel_hi)) |-> !data_oe);
    // R9
    sel_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_now) |-> !irq_n);
    // R11
    rst_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (irq_n && !data_oe && data_out == '0));
endmodule

// File: tb/strobed_io_port_tb.sv
module strobed_io_port_tb;
    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          sel_lo_n = 1'b1, sel_hi = 1'b0, out_mode = 1'b0;
    logic          strobe = 1'b0, clear_n = 1'b1;
    logic [DW-1:0] data_out;
    logic          data_oe, irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    strobed_io_port #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .sel_lo_n(sel_lo_n),
        .sel_hi(sel_hi), .out_mode(out_mode), .strobe(strobe), .clear_n(clear_n),
        .data_out(data_out), .data_oe(data_oe), .irq_n(irq_n));

    // behavioural reference: inputs age two edges, then act
    logic [DW+4:0] hist[$];
    logic [DW-1:0] m_data;
    logic          m_flag, m_prev, m_sel, m_oe;
    localparam logic [DW+4:0] IDLE_IN = {{DW{1'b0}}, 5'b10001};

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{IDLE_IN, IDLE_IN};
            m_data = '0; m_flag = 0; m_prev = 0; m_sel = 0; m_oe = 0;
        end else begin
            logic [DW+4:0] u;
            logic s, g, fall, wipe;
            u = hist.pop_front();
            hist.push_back({data_in, sel_lo_n, sel_hi, out_mode, strobe, clear_n});
            s    = !u[4] && u[3];
            g    = u[2] ? s : u[1];
            fall = m_prev && !u[1];
            wipe = s || !u[0];
            if (g) m_data = u[DW+4:5];
            else if (!u[0]) m_data = '0;
            if (wipe) m_flag = 0;
            else if (fall) m_flag = 1;
            m_prev = u[1];
            m_sel = s;
            m_oe = u[2] || s;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 model data_out", int'(data_out), int'(m_data));
            check("R3 model data_oe", int'(data_oe), int'(m_oe));
            check("R9 model irq_n", int'(irq_n), int'(!(m_flag || m_sel)));
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset data_out", int'(data_out), 0);
        check("R11 reset data_oe", int'(data_oe), 0);
        check("R11 reset irq_n", int'(irq_n), 1);
        rst_n = 1'b1;
        settle();
        check("R11 after reset irq_n", int'(irq_n), 1);

        // input mode, unselected, strobe high: latch follows, drivers off
        strobe = 1; data_in = 8'hA5; settle();
        check("R3 unselected strobe high oe", int'(data_oe), 0);
        check("R4 follow with strobe", int'(data_out), 'hA5);
        check("R9 no request yet", int'(irq_n), 1);
        strobe = 0; settle();
        check("R7 falling strobe sets irq", int'(irq_n), 0);
        check("R3 unselected strobe low oe", int'(data_oe), 0);
        data_in = 8'h3C; settle();
        check("R4 hold with gate low", int'(data_out), 'hA5);

        // select decode
        sel_lo_n = 1; sel_hi = 1; settle();
        check("R1 both high not selected", int'(data_oe), 0);
        sel_lo_n = 0; sel_hi = 0; settle();
        check("R1 both low not selected", int'(data_oe), 0);
        sel_lo_n = 0; sel_hi = 1; settle();
        check("R1 selected enables drivers", int'(data_oe), 1);
        check("R9 select drives irq low", int'(irq_n), 0);
        check("R4 input-mode select does not gate latch", int'(data_out), 'hA5);
        sel_lo_n = 1; sel_hi = 0; settle();
        check("R8 select cleared the flag", int'(irq_n), 1);

        // output mode
        out_mode = 1; settle();
        check("R2 output mode oe unselected", int'(data_oe), 1);
        strobe = 1; data_in = 8'h5A; settle();
        check("R2 strobe ignored by latch", int'(data_out), 'hA5);
        strobe = 0; settle();
        check("R7 strobe fall in output mode", int'(irq_n), 0);
        sel_lo_n = 0; sel_hi = 1; settle();
        check("R2 select gates latch", int'(data_out), 'h5A);
        sel_lo_n = 1; sel_hi = 0; settle();
        check("R8 flag cleared after select", int'(irq_n), 1);
        check("R2 hold after deselect", int'(data_out), 'h5A);

        // latency
        sel_lo_n = 0; sel_hi = 1; data_in = 8'h11; settle();
        data_in = 8'h22;
        repeat (2) @(negedge clk);
        check("R10 unchanged after two edges", int'(data_out), 'h11);
        @(negedge clk);
        check("R10 changed after third edge", int'(data_out), 'h22);
        sel_lo_n = 1; sel_hi = 0; out_mode = 0; settle();

        // clear paths
        strobe = 1; data_in = 8'h77; settle();
        strobe = 0; settle();
        check("R7 flag set before clear", int'(irq_n), 0);
        clear_n = 0; settle();
        check("R5 clear zeroes latch", int'(data_out), 0);
        check("R6 clear drops flag", int'(irq_n), 1);
        strobe = 1; data_in = 8'h99; settle();
        check("R5 high gate overrides clear", int'(data_out), 'h99);
        strobe = 0; settle();
        check("R7 clear wins over fall", int'(irq_n), 1);
        check("R5 clear after gate drops", int'(data_out), 0);
        clear_n = 1; settle();

        // same-cycle fall and clear
        strobe = 1; data_in = 8'h44; settle();
        @(negedge clk); strobe = 0; clear_n = 0;
        @(negedge clk); clear_n = 1;
        settle();
        check("R7 same-cycle clear wins", int'(irq_n), 1);
        check("R5 same-cycle clear latch", int'(data_out), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        done = 1;
        failures++;
        checks++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule